// File: doc/BRIEF.md
# User-Mode SPI Flash Access Bridge

This bridge lets a processor reach serial flash devices through memory accesses. It has one request port with two address spaces. The register space holds a shared configuration word and one control word per flash device. The window space gives each device its own slice of addresses. When a device's control word selects user mode, an access of 1 to 4 bytes to its window becomes the same number of SPI byte transfers. A read shifts out zero bytes and returns the received bytes packed little-endian. A write shifts out the data bytes, least significant byte first. The bridge drives an active-low chip-select line for each device straight from a software-written stop bit. Framing a flash command is therefore left to software: it clears the stop bit, sends the command, address and data bytes through the window, and then sets the stop bit again.

The controller is a four-state machine that feeds a mode-0 byte shifter:
- **IDLE** waits for `bus_req`. A register access, or a window access that is refused, goes straight to DONE. An accepted window access goes to LOAD.
- **LOAD** starts one byte on the shifter and always moves to SHIFT.
- **SHIFT** waits for the shifter to report that the byte is finished. If more bytes remain, it returns to LOAD. After the last byte it goes to DONE.
- **DONE** raises `bus_ready` for exactly one cycle and then returns to IDLE.

Top module: `spi_user_bridge`

## Requirements
- R1: Bits [1:0] of a control word set the access mode: 0 = read, 1 = fast read, 2 = write, 3 = user. Only mode 3 lets window accesses reach the SPI bus.
- R2: Bit 2 of control word n is the stop flag. `spi_cs_n[n]` equals that bit: high (inactive) when it is set, low when it is clear. The line takes its new value in the cycle after the register write, which is the cycle in which `bus_ready` is high.
- R3: Bit 16+n of the configuration word enables writes to device n. A window write to a device whose bit is clear completes with no SPI activity.
- R4: A user-mode window read of N bytes runs N transfers and shifts out 0x00 in each one. Received byte k is returned in `bus_rdata[8k+7:8k]`, and the unused upper bytes read as zero.
- R5: A user-mode window write of N bytes runs N transfers and sends `bus_wdata[7:0]` first, then the higher bytes in order.
- R6: A window read in any mode other than user returns 0xFFFFFFFF. A window write in any mode other than user is dropped. Neither one toggles `spi_sclk`.
- R7: After reset: the configuration word is 0, the interrupt word is 0x00000800, every control word is 0x00000004, and all `spi_cs_n` lines are high.
- R8: Control word bits [23:16] hold a command byte that reads back as written. `bus_size` encodes N-1, so the values 0 to 3 select access sizes of 1 to 4 bytes.
- R9: `bus_ready` stays low until every byte of a window access has finished and is then high for exactly one cycle. A register access completes one cycle after it is accepted.
- R10: The SPI bus runs in mode 0, MSB first. `spi_sclk` idles low, each phase of `spi_sclk` lasts DIV clock cycles, and `spi_miso` is sampled on the rising edge.
- R11: Register offsets that have no register behind them read as zero and ignore writes.
- Register word offsets: configuration at 0x00, interrupt at 0x08, and control word n at 0x10+4n. The device index of a window access is taken from `bus_addr[WIN_BITS+CS_W-1:WIN_BITS]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held high until `bus_ready` is seen |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 1 = flash window space, 0 = register space |
| bus_addr | input | ADDR_W | Byte address inside the selected space |
| bus_size | input | 2 | Access size minus one, in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| bus_ready | output | 1 | One-cycle completion strobe |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | SPI data out |
| spi_miso | input | 1 | SPI data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects, one per device |

## Verification
The assertions check the following on every cycle:
- a write to a control word moves the matching chip-select line in the next cycle;
- refused window accesses, whether from a non-user mode or a missing write enable, complete at once with the right read value;
- `bus_ready` is a single-cycle strobe;
- `spi_sclk` rests low whenever the controller is idle.

The bench scenarios cover what needs knowledge of the byte stream:
- the byte order on MOSI;
- the little-endian packing of the bytes received on MISO;
- the number of transfers for each access size;
- the `spi_sclk` period;
- the reset values, command-byte readback and unmapped offsets, all checked through register reads.

// File: rtl/spiub_pkg.sv
package spiub_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

    localparam logic [1:0]  MODE_USER   = 2'd3;
    localparam int          STOP_BIT    = 2;
    localparam int          WEN_BASE    = 16;
    localparam logic [5:0]  IDX_CONF    = 6'd0;
    localparam logic [5:0]  IDX_INTR    = 6'd2;
    localparam int          IDX_CTRL0   = 4;
    localparam logic [31:0] INTR_RESET  = 32'h0000_0800;
    localparam logic [31:0] CTRL_RESET  = 32'h0000_0004;
endpackage

// File: rtl/spiub_regs.sv
module spiub_regs
    import spiub_pkg::*;
#(
    parameter int NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [5:0]        widx,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CS-1:0] user_vec,
    output logic [NUM_CS-1:0] stop_vec,
    output logic [NUM_CS-1:0] wen_vec
);
    logic [31:0] conf_q;
    logic [31:0] intr_q;
    logic [31:0] ctrl_q [NUM_CS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conf_q <= '0;
            intr_q <= INTR_RESET;
        end else if (wr_en) begin
            if (widx == IDX_CONF) conf_q <= wdata;
            if (widx == IDX_INTR) intr_q <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_ctrl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl_q[g] <= CTRL_RESET;
            end else if (wr_en && widx == 6'(IDX_CTRL0 + g)) begin
                ctrl_q[g] <= wdata;
            end
        end
        assign user_vec[g] = (ctrl_q[g][1:0] == MODE_USER);
        assign stop_vec[g] = ctrl_q[g][STOP_BIT];
        assign wen_vec[g]  = conf_q[WEN_BASE + g];
    end

    always_comb begin
        rdata = '0;
        if (widx == IDX_CONF) rdata = conf_q;
        if (widx == IDX_INTR) rdata = intr_q;
        for (int i = 0; i < NUM_CS; i++) begin
            if (widx == 6'(IDX_CTRL0 + i)) rdata = ctrl_q[i];
        end
    end
endmodule

// File: rtl/spiub_shift.sv
module spiub_shift #(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx,
    output logic       sclk,
    output logic       mosi
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          samp_q;
    logic          tick;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bit_q  <= '0;
            sh_q   <= '0;
            samp_q <= 1'b0;
            busy   <= 1'b0;
            done   <= 1'b0;
            sclk   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy  <= 1'b1;
                sh_q  <= tx;
                cnt_q <= '0;
                bit_q <= '0;
                sclk  <= 1'b0;
            end else if (busy) begin
                if (tick) begin
                    cnt_q <= '0;
                    if (!sclk) begin
                        sclk   <= 1'b1;
                        samp_q <= miso;
                    end else begin
                        sclk  <= 1'b0;
                        sh_q  <= {sh_q[6:0], samp_q};
                        bit_q <= bit_q + 3'd1;
                        if (bit_q == 3'd7) begin
                            busy <= 1'b0;
                            done <= 1'b1;
                        end
                    end
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    assign rx   = sh_q;
    assign mosi = busy & sh_q[7];
endmodule

// File: rtl/spi_user_bridge.sv
module spi_user_bridge
    import spiub_pkg::*;
#(
    parameter int NUM_CS   = 2,
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 12,
    parameter int DIV      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_win,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NUM_CS-1:0] spi_cs_n
);
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    st_e         state_q, state_d;
    logic [1:0]  k_q, n_q;
    logic [31:0] wdat_q, rdat_q;

    logic [NUM_CS-1:0] user_vec, stop_vec, wen_vec;
    logic [31:0]       reg_rdata;
    logic [CS_W-1:0]   cs_idx;
    logic              sel_ok, user_sel, wen_sel, go, reg_wr;
    logic              sh_start, sh_busy, sh_done;
    logic [7:0]        sh_tx, sh_rx;
    logic              unused_ok;

    assign unused_ok = ^{bus_addr, sh_busy};

    assign cs_idx   = bus_addr[WIN_BITS +: CS_W];
    assign sel_ok   = (32'(cs_idx) < NUM_CS);
    assign user_sel = sel_ok && user_vec[cs_idx];
    assign wen_sel  = sel_ok && wen_vec[cs_idx];
    assign go       = user_sel && (!bus_we || wen_sel);
    assign reg_wr   = (state_q == ST_IDLE) && bus_req && bus_we && !bus_win;

    spiub_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .widx     (bus_addr[7:2]),
        .wdata    (bus_wdata),
        .rdata    (reg_rdata),
        .user_vec (user_vec),
        .stop_vec (stop_vec),
        .wen_vec  (wen_vec)
    );

    spiub_shift #(.DIV(DIV)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .tx    (sh_tx),
        .miso  (spi_miso),
        .busy  (sh_busy),
        .done  (sh_done),
        .rx    (sh_rx),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (bus_req) state_d = (bus_win && go) ? ST_LOAD : ST_DONE;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (sh_done) state_d = (k_q == n_q) ? ST_DONE : ST_LOAD;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            k_q    <= '0;
            n_q    <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else if (state_q == ST_IDLE && bus_req) begin
            if (!bus_win) begin
                rdat_q <= bus_we ? 32'h0 : reg_rdata;
            end else if (go) begin
                rdat_q <= '0;
                n_q    <= bus_size;
                k_q    <= '0;
                wdat_q <= bus_we ? bus_wdata : 32'h0;
            end else begin
                rdat_q <= bus_we ? 32'h0 : 32'hFFFF_FFFF;
            end
        end else if (state_q == ST_SHIFT && sh_done) begin
            rdat_q[8*k_q +: 8] <= sh_rx;
            k_q                <= k_q + 2'd1;
        end
    end

    // outputs
    always_comb begin
        bus_ready = (state_q == ST_DONE);
        sh_start  = (state_q == ST_LOAD);
        sh_tx     = wdat_q[8*k_q +: 8];
        bus_rdata = rdat_q;
        spi_cs_n  = stop_vec;
    end
endmodule

// File: rtl/spiub_chk.sv
module spiub_chk #(
    parameter int NUM_CS = 2,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_win,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_ready,
    input logic              spi_sclk,
    input logic [NUM_CS-1:0] spi_cs_n,
    input logic              idle,
    input logic              user_sel,
    input logic              wen_sel
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        p_cs_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (idle && bus_req && bus_we && !bus_win && bus_addr[7:2] == 6'(4 + g))
            |=> (spi_cs_n[g] == $past(bus_wdata[2])));
    end

    p_wr_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && bus_req && bus_we && bus_win && user_sel && !wen_sel)
        |=> (bus_ready && !spi_sclk));

    p_nonuser_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && bus_req && bus_win && !user_sel)
        |=> (bus_ready && bus_rdata == ($past(bus_we) ? 32'h0 : 32'hFFFF_FFFF)));

    p_ready_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    p_sclk_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !spi_sclk);
endmodule

bind spi_user_bridge spiub_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_win   (bus_win),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .spi_sclk  (spi_sclk),
    .spi_cs_n  (spi_cs_n),
    .idle      (state_q == spiub_pkg::ST_IDLE),
    .user_sel  (user_sel),
    .wen_sel   (wen_sel)
);

// File: tb/sim_spi_user_bridge.sv
`timescale 1ns/1ps
module sim_spi_user_bridge;
    localparam int NUM_CS = 2;
    localparam int ADDR_W = 16;
    localparam int WIN_BITS = 12;
    localparam int DIV = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0, bus_win = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [1:0] bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_ready, spi_sclk, spi_mosi, spi_miso;
    logic [NUM_CS-1:0] spi_cs_n;

    always #10 clk = ~clk;

    spi_user_bridge #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_win(bus_win),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    int n_chk = 0;
    int n_bad = 0;

    // SPI device model: mode 0, MSB first, answers C1, D2, E3, F4 ...
    int bcnt = 0;
    int bidx = 0;
    int rises = 0;
    realtime t_r1 = 0, t_r2 = 0;
    logic [7:0] cur = '0;
    logic [31:0] mosi_log = '0;
    logic [7:0] resp_cur;
    always_comb resp_cur = 8'hC1 + 8'h11 * bcnt[7:0];
    assign spi_miso = resp_cur[3'(7 - bidx)];

    always @(posedge spi_sclk) begin
        cur = {cur[6:0], spi_mosi};
        rises = rises + 1;
        if (rises == 1) t_r1 = $realtime;
        if (rises == 2) t_r2 = $realtime;
    end
    always @(negedge spi_sclk) begin
        bidx = bidx + 1;
        if (bidx == 8) begin
            if (bcnt < 4) mosi_log[8*bcnt +: 8] = cur;
            bcnt = bcnt + 1;
            bidx = 0;
        end
    end

    task automatic clear_dev();
        bcnt = 0; bidx = 0; rises = 0; mosi_log = '0; cur = '0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic we, input logic win, input logic [ADDR_W-1:0] addr,
                       input logic [1:0] sz, input logic [31:0] wd,
                       output logic [31:0] rd, output int cyc);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_win = win; bus_addr = addr;
        bus_size = sz; bus_wdata = wd;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!bus_ready);
        rd = bus_rdata;
        bus_req = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic        cs;
        logic [1:0]  szm1;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic [7:0]  exp_cnt;
        logic [31:0] exp_mosi;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 2'd0, 32'h0,        32'h0000_00C1, 8'd1, 32'h0},
        '{1'b0, 1'b0, 2'd3, 32'h0,        32'hF4E3_D2C1, 8'd4, 32'h0},
        '{1'b1, 1'b0, 2'd2, 32'h11A5_3C81, 32'h0,        8'd3, 32'h00A5_3C81},
        '{1'b1, 1'b0, 2'd3, 32'hDEAD_BEEF, 32'h0,        8'd4, 32'hDEAD_BEEF},
        '{1'b1, 1'b1, 2'd1, 32'h0000_BEEF, 32'h0,        8'd0, 32'h0},
        '{1'b0, 1'b1, 2'd1, 32'h0,        32'h0000_D2C1, 8'd2, 32'h0}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog R9 actual=hung expected=completion");
        summary();
    end

    initial begin
        logic [31:0] rd;
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 reset state
        chk("R7 cs_n reset", 32'(spi_cs_n), 32'h3);
        acc(0, 0, 16'h00, 0, 0, rd, cyc); chk("R7 conf reset", rd, 32'h0);
        acc(0, 0, 16'h08, 0, 0, rd, cyc); chk("R7 intr reset", rd, 32'h800);
        acc(0, 0, 16'h10, 0, 0, rd, cyc); chk("R7 ctrl0 reset", rd, 32'h4);
        acc(0, 0, 16'h14, 0, 0, rd, cyc); chk("R7 ctrl1 reset", rd, 32'h4);
        chk("R9 reg access latency", 32'(cyc), 32'd1);

        // R11 unmapped offsets
        acc(1, 0, 16'h0C, 0, 32'hFFFF_FFFF, rd, cyc);
        acc(1, 0, 16'h40, 0, 32'hFFFF_FFFF, rd, cyc);
        acc(0, 0, 16'h0C, 0, 0, rd, cyc); chk("R11 unmapped reads zero", rd, 32'h0);
        acc(0, 0, 16'h00, 0, 0, rd, cyc); chk("R11 conf untouched", rd, 32'h0);
        acc(0, 0, 16'h10, 0, 0, rd, cyc); chk("R11 ctrl0 untouched", rd, 32'h4);

        // R2 / R8 control words
        acc(1, 0, 16'h10, 0, 32'h00AB_0003, rd, cyc);
        chk("R2 cs0 active after clear", 32'(spi_cs_n), 32'h2);
        acc(0, 0, 16'h10, 0, 0, rd, cyc); chk("R8 command byte readback", rd, 32'h00AB_0003);
        acc(1, 0, 16'h14, 0, 32'h0000_0003, rd, cyc);
        chk("R2 both active", 32'(spi_cs_n), 32'h0);
        acc(1, 0, 16'h00, 0, 32'h0001_0000, rd, cyc);   // R3: only cs0 writable

        // table of user-mode window accesses (R3, R4, R5, R8)
        for (int i = 0; i < 6; i++) begin
            clear_dev();
            acc(VECS[i].we, 1, 16'(32'(VECS[i].cs) << WIN_BITS), VECS[i].szm1,
                VECS[i].wdata, rd, cyc);
            if (!VECS[i].we) chk($sformatf("R4 read data vec%0d", i), rd, VECS[i].exp_rd);
            chk($sformatf("R3/R8 transfer count vec%0d", i), 32'(bcnt), 32'(VECS[i].exp_cnt));
            chk($sformatf("R5 mosi bytes vec%0d", i), mosi_log, VECS[i].exp_mosi);
            if (i == 1) begin
                chk("R9 ready held through 4 bytes", 32'(cyc >= 4*16*DIV), 32'd1);
                chk("R10 sclk period", 32'(int'((t_r2 - t_r1) / 1ns)), 32'(2*DIV*20));
            end
            chk($sformatf("R10 sclk idle low vec%0d", i), 32'(spi_sclk), 32'd0);
        end

        // R1 / R6 non-user modes
        for (int m = 0; m < 3; m++) begin
            acc(1, 0, 16'h14, 0, 32'(m), rd, cyc);
            clear_dev();
            acc(0, 1, 16'h1000, 3, 0, rd, cyc);
            chk($sformatf("R1/R6 mode %0d read ones", m), rd, 32'hFFFF_FFFF);
            chk($sformatf("R6 mode %0d no transfers", m), 32'(bcnt), 32'd0);
        end
        acc(1, 0, 16'h10, 0, 32'h0000_0002, rd, cyc);
        clear_dev();
        acc(1, 1, 16'h0000, 1, 32'h1234, rd, cyc);
        chk("R6 write-mode write dropped", 32'(bcnt), 32'd0);

        // R2 stop bit set again
        acc(1, 0, 16'h10, 0, 32'h0000_0007, rd, cyc);
        chk("R2 cs0 inactive on stop", 32'(spi_cs_n[0]), 32'd1);
        clear_dev();
        acc(0, 1, 16'h0000, 0, 0, rd, cyc);
        chk("R4 user read with stop set", rd, 32'h0000_00C1);

        summary();
    end
endmodule